// File: doc/BRIEF.md
# Auto-Baud Serial Boot Handshake Controller

This block brings up a serial link whose speed is not known in advance. After reset it watches the receive line while a host repeatedly sends zero-valued bytes. In an 8N1 frame a zero byte holds the line low for nine bit times: the start bit and eight zero data bits. The block counts the clock cycles of each such low stretch. When two back-to-back stretches agree closely, it derives the bit period in clock cycles and keeps it as the divisor. That divisor drives an internal 8N1 transmitter and receiver.

With the divisor set, the block sends a single zero byte to tell the host that the rate is locked. It then listens for a single confirm byte of value 0x55. A correct confirm ends the handshake. Both transfer enables are then cleared, and the divisor stays visible for whatever runs next. A wrong byte or a bad stop bit parks the block in a failed state. Only a reset leaves either terminal state.

The controller states are ARM, MEASURE, LOAD, ACK, CONFIRM, DONE and FAIL. Its transitions are:
- ARM to MEASURE once the synchronised line is high.
- MEASURE to LOAD when two spans agree.
- LOAD to ACK in one cycle, starting the transmitter.
- ACK to CONFIRM when the acknowledge frame ends.
- CONFIRM to DONE on 0x55 with a valid stop bit, and CONFIRM to FAIL on anything else.
- DONE and FAIL hold until reset.

Top module: `baud_lock_boot`

## Requirements
- R1: While reset is held and on the first cycle after it, txd is 1, divisor is 0, and done, fail, rx_en and tx_en are all 0.
- R2: Measurement is armed only once the receive line is seen high after reset. A low level already present at reset release is never counted as a span, so a single zero byte that follows it yields no lock.
- R3: A span is the number of clock cycles the line stays low. When a new span b and the previous reference span a satisfy |b-a| <= a/32, the block locks and sets divisor = floor((a+b+9)/18). The divisor then stays unchanged until reset.
- R4: A span that disagrees with the reference replaces it, and measuring continues. No acknowledge is sent and divisor stays 0.
- R5: A span shorter than 36 cycles (9 times the minimum divisor of 4) is discarded and leaves the reference span unchanged. The same applies to a span that saturates the 16-bit counter.
- R6: After lock, exactly one frame is sent on txd at the divisor's bit period: start bit 0, data 0x00 least significant bit first, stop bit 1. txd is 1 whenever tx_en is 0.
- R7: In CONFIRM, the receiver samples each bit mid-bit, half a divisor after start detection and then every divisor cycles. A received 0x55 with stop bit 1 sets done. It also clears rx_en and tx_en, leaves txd at 1 and keeps divisor.
- R8: A received byte other than 0x55 in CONFIRM sets fail. done stays 0.
- R9: A stop bit sampled as 0 in CONFIRM sets fail, even when the data is 0x55.
- R10: done and fail are never both 1. Each holds until reset, and no further frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line from host, idles high |
| txd | output | 1 | Serial line to host, idles high |
| divisor | output | CNT_W-2 | Locked bit period in clock cycles, 0 before lock |
| rx_en | output | 1 | Receiver active (CONFIRM) |
| tx_en | output | 1 | Transmit path active (LOAD, ACK, CONFIRM) |
| done | output | 1 | Handshake completed |
| fail | output | 1 | Handshake failed, reset required |

## Verification
The lock is driven with several host patterns. Two identical zero bytes at two different bit periods show that the divisor follows the measured rate. Two zero bytes whose low spans differ slightly but stay within tolerance exercise the rounding of the averaged period. A rate change between bytes checks that a mismatching span becomes the new reference rather than forcing a lock. A line held low across reset release, followed by a single zero byte and then a short glitch, separates correct arming and glitch rejection from a design that counts too early or lets a glitch reset the reference. The confirm phase is then tried with the right byte, a wrong byte, and the right byte with a missing stop bit, which separates the DONE and FAIL transitions.

// File: rtl/baud_lock_pkg.sv
package baud_lock_pkg;

    typedef enum logic [2:0] {
        LK_ARM,
        LK_MEASURE,
        LK_LOAD,
        LK_ACK,
        LK_CONFIRM,
        LK_DONE,
        LK_FAIL
    } lock_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam logic [7:0] ACK_BYTE      = 8'h00;
    localparam logic [7:0] CONFIRM_BYTE  = 8'h55;
    localparam int         ZERO_LOW_BITS = 9;

endpackage

// File: rtl/lowspan_meter.sv
module lowspan_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    output logic [CNT_W-1:0] span,
    output logic             span_vld,
    output logic             span_sat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            span     <= '0;
            span_vld <= 1'b0;
            span_sat <= 1'b0;
        end else begin
            prev_q   <= line;
            span_vld <= 1'b0;
            if (!en) begin
                armed_q <= 1'b0;
            end else if (prev_q && !line) begin
                armed_q <= 1'b1;
                cnt_q   <= CNT_W'(1);
            end else if (armed_q && !line) begin
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (armed_q && line && !prev_q) begin
                span     <= cnt_q;
                span_sat <= (cnt_q == CNT_MAX);
                span_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       data,
    output logic             txd,
    output logic             fin
);

    logic             busy_q;
    logic [DIV_W-1:0] tick_q;
    logic [3:0]       bitn_q;
    logic [9:0]       shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            tick_q  <= '0;
            bitn_q  <= '0;
            shreg_q <= '1;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    shreg_q <= {1'b1, data, 1'b0};
                    busy_q  <= 1'b1;
                    tick_q  <= '0;
                    bitn_q  <= '0;
                end
            end else if (tick_q == div - DIV_W'(1)) begin
                tick_q <= '0;
                if (bitn_q == 4'd9) begin
                    busy_q <= 1'b0;
                    fin    <= 1'b1;
                end else begin
                    bitn_q  <= bitn_q + 4'd1;
                    shreg_q <= {1'b1, shreg_q[9:1]};
                end
            end else begin
                tick_q <= tick_q + DIV_W'(1);
            end
        end
    end

    assign txd = busy_q ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/boot_uart_rx.sv
module boot_uart_rx
    import baud_lock_pkg::*;
#(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    input  logic [DIV_W-1:0] div,
    output logic [7:0]       data,
    output logic             stop_ok,
    output logic             vld
);

    rx_state_e        st_q;
    logic [DIV_W-1:0] tick_q;
    logic [2:0]       bitn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            tick_q  <= '0;
            bitn_q  <= '0;
            data    <= '0;
            stop_ok <= 1'b0;
            vld     <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (!en) begin
                st_q <= RX_IDLE;
            end else begin
                unique case (st_q)
                    RX_IDLE: begin
                        if (!line) begin
                            st_q   <= RX_START;
                            tick_q <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick_q == (div >> 1)) begin
                            tick_q <= '0;
                            bitn_q <= '0;
                            st_q   <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tick_q <= tick_q + DIV_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (tick_q == div - DIV_W'(1)) begin
                            tick_q <= '0;
                            data   <= {line, data[7:1]};
                            bitn_q <= bitn_q + 3'd1;
                            if (bitn_q == 3'd7) begin
                                st_q <= RX_STOP;
                            end
                        end else begin
                            tick_q <= tick_q + DIV_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (tick_q == div - DIV_W'(1)) begin
                            stop_ok <= line;
                            vld     <= 1'b1;
                            st_q    <= RX_IDLE;
                        end else begin
                            tick_q <= tick_q + DIV_W'(1);
                        end
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/baud_lock_boot.sv
module baud_lock_boot
    import baud_lock_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TOL_SHIFT = 5,
    parameter int MIN_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    output logic             txd,
    output logic [CNT_W-3:0] divisor,
    output logic             rx_en,
    output logic             tx_en,
    output logic             done,
    output logic             fail
);

    localparam int DIV_W    = CNT_W - 2;
    localparam int SUM_W    = CNT_W + 1;
    localparam int MIN_SPAN = ZERO_LOW_BITS * MIN_DIV;

    lock_state_e state_q, state_d;

    logic [1:0]       sync_q;
    logic             line;
    logic [CNT_W-1:0] span;
    logic             span_vld;
    logic             span_sat;
    logic [CNT_W-1:0] ref_q;
    logic             ref_ok_q;
    logic [CNT_W-1:0] diff;
    logic             span_good;
    logic             agree;
    logic             accept;
    logic             meter_en;
    logic             tx_start;
    logic             tx_fin;
    logic             rx_on;
    logic [7:0]       rx_byte;
    logic             rx_stop_ok;
    logic             rx_vld;

    // two-stage synchroniser, reset low so a held-low line is never seen as a fall
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], rxd};
        end
    end
    assign line = sync_q[1];

    lowspan_meter #(.CNT_W(CNT_W)) meter_i (
        .clk      (clk),
        .rst      (rst),
        .en       (meter_en),
        .line     (line),
        .span     (span),
        .span_vld (span_vld),
        .span_sat (span_sat)
    );

    boot_uart_tx #(.DIV_W(DIV_W)) tx_i (
        .clk   (clk),
        .rst   (rst),
        .div   (divisor),
        .start (tx_start),
        .data  (ACK_BYTE),
        .txd   (txd),
        .fin   (tx_fin)
    );

    boot_uart_rx #(.DIV_W(DIV_W)) rx_i (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_on),
        .line    (line),
        .div     (divisor),
        .data    (rx_byte),
        .stop_ok (rx_stop_ok),
        .vld     (rx_vld)
    );

    // span qualification and agreement test
    always_comb begin
        diff      = (span > ref_q) ? (span - ref_q) : (ref_q - span);
        span_good = span_vld && !span_sat && (span >= CNT_W'(MIN_SPAN));
        agree     = ref_ok_q && (diff <= (ref_q >> TOL_SHIFT));
        accept    = (state_q == LK_MEASURE) && span_good && agree;
    end

    // reference span and locked divisor
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= '0;
            ref_ok_q <= 1'b0;
            divisor  <= '0;
        end else if (state_q == LK_MEASURE && span_good) begin
            if (agree) begin
                divisor <= DIV_W'(({1'b0, span} + {1'b0, ref_q} + SUM_W'(ZERO_LOW_BITS))
                                  / SUM_W'(2 * ZERO_LOW_BITS));
            end else begin
                ref_q    <= span;
                ref_ok_q <= 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_ARM:     if (line) state_d = LK_MEASURE;
            LK_MEASURE: if (accept) state_d = LK_LOAD;
            LK_LOAD:    state_d = LK_ACK;
            LK_ACK:     if (tx_fin) state_d = LK_CONFIRM;
            LK_CONFIRM: begin
                if (rx_vld) begin
                    state_d = (rx_byte == CONFIRM_BYTE && rx_stop_ok) ? LK_DONE : LK_FAIL;
                end
            end
            LK_DONE:    state_d = LK_DONE;
            LK_FAIL:    state_d = LK_FAIL;
            default:    state_d = LK_ARM;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        meter_en = (state_q == LK_MEASURE);
        tx_start = (state_q == LK_LOAD);
        rx_on    = (state_q == LK_CONFIRM);
        rx_en    = rx_on;
        tx_en    = (state_q == LK_LOAD) || (state_q == LK_ACK) || (state_q == LK_CONFIRM);
        done     = (state_q == LK_DONE);
        fail     = (state_q == LK_FAIL);
    end

endmodule

// File: rtl/baud_lock_boot_chk.sv
module baud_lock_boot_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         txd,
    input logic [W-1:0] divisor,
    input logic         rx_en,
    input logic         tx_en,
    input logic         done,
    input logic         fail
);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fail |=> fail);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (txd && !rx_en && !tx_en));

    assert_divisor_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (divisor != '0) |=> $stable(divisor));

    assert_tx_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> txd);

endmodule

bind baud_lock_boot baud_lock_boot_chk #(.W(CNT_W - 2)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .txd     (txd),
    .divisor (divisor),
    .rx_en   (rx_en),
    .tx_en   (tx_en),
    .done    (done),
    .fail    (fail)
);

// File: tb/baud_lock_boot_tb_top.sv
module baud_lock_boot_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        txd;
    logic [13:0] divisor;
    logic        rx_en;
    logic        tx_en;
    logic        done;
    logic        fail;

    int total     = 0;
    int bad       = 0;
    int phase     = 9;
    int exp_div   = 0;
    int clk_bad   = 0;
    int ack_frames = 0;
    logic [7:0] ack_byte = 8'hff;
    logic       ack_stop = 1'b0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    baud_lock_boot dut_i (
        .clk     (clk),
        .rst     (rst),
        .rxd     (rxd),
        .txd     (txd),
        .divisor (divisor),
        .rx_en   (rx_en),
        .tx_en   (tx_en),
        .done    (done),
        .fail    (fail)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference of the visible phase, compared every clock
    always @(negedge clk) begin
        if (!rst) begin
            bit ok;
            ok = 1'b1;
            case (phase)
                0: ok = !done && !fail && !tx_en && !rx_en && txd && divisor == 14'd0;
                1: ok = !done && !fail && int'(divisor) == exp_div;
                2: ok = done && !fail && txd && !rx_en && !tx_en && int'(divisor) == exp_div;
                3: ok = !done && fail && txd && !rx_en && !tx_en && int'(divisor) == exp_div;
                default: ok = 1'b1;
            endcase
            if (!ok) begin
                clk_bad++;
                if (clk_bad < 5) $display("model mismatch t=%0t phase=%0d", $time, phase);
            end
        end
    end

    // host-side decoder of frames sent on txd
    initial begin : ack_mon
        logic       prev_t;
        logic [7:0] got;
        logic       st_low;
        prev_t = 1'b1;
        got    = 8'h00;
        st_low = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && prev_t && !txd) begin
                repeat (exp_div / 2) @(negedge clk);
                st_low = !txd;
                for (int i = 0; i < 8; i++) begin
                    repeat (exp_div) @(negedge clk);
                    got[i] = txd;
                end
                repeat (exp_div) @(negedge clk);
                ack_stop = txd && st_low;
                ack_byte = got;
                ack_frames++;
            end
            prev_t = txd;
        end
    end

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_zero(input int low, input int bitp, input bit last);
        hold(1'b0, low);
        if (last) phase = 9;
        hold(1'b1, bitp);
    endtask

    task automatic send_byte(input logic [7:0] b, input int bitp, input logic stop_lvl,
                             input int end_phase);
        hold(1'b0, bitp);
        for (int i = 0; i < 8; i++) hold(b[i], bitp);
        phase = 9;
        hold(stop_lvl, bitp);
        hold(1'b1, 3);
        phase = end_phase;
    endtask

    task automatic do_reset(input logic lvl, input int ediv);
        @(negedge clk);
        phase      = 9;
        rst        = 1'b1;
        rxd        = lvl;
        exp_div    = ediv;
        ack_frames = 0;
        clk_bad    = 0;
        repeat (8) @(negedge clk);
        check(txd && !done && !fail && !rx_en && !tx_en && divisor == 14'd0,
              "R1", "outputs under reset", int'({txd, done, fail, rx_en, tx_en}), 16);
        rst = 1'b0;
        @(negedge clk);
        check(txd && !done && !fail && !rx_en && !tx_en && divisor == 14'd0,
              "R1", "outputs after reset", int'(divisor), 0);
        phase = 0;
    endtask

    task automatic wait_ack();
        int n;
        n = 0;
        while (ack_frames == 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (exp_div + 10) @(negedge clk);
    endtask

    initial begin
        // S1: equal zero bytes at 20 cycles per bit, good confirm
        do_reset(1'b1, 20);
        hold(1'b1, 30);
        send_zero(180, 20, 1'b0);
        send_zero(180, 20, 1'b1);
        phase = 1;
        check(int'(divisor) == 20, "R3", "divisor after lock at 20", int'(divisor), 20);
        wait_ack();
        check(ack_frames == 1, "R6", "one ack frame", ack_frames, 1);
        check(ack_byte == 8'h00, "R6", "ack data", int'(ack_byte), 0);
        check(ack_stop, "R6", "ack start/stop levels", int'(ack_stop), 1);
        send_byte(8'h55, 20, 1'b1, 2);
        check(done && !rx_en && !tx_en && txd && int'(divisor) == 20,
              "R7", "done after 0x55", int'({done, rx_en, tx_en, txd}), 9);
        repeat (200) @(negedge clk);
        check(done && !fail && ack_frames == 1, "R10", "done held, no extra frame",
              ack_frames, 1);
        check(clk_bad == 0, "R10", "per-clock model S1", clk_bad, 0);

        // S2: spans 333 and 341 within tolerance, wrong confirm byte
        do_reset(1'b1, 37);
        hold(1'b1, 40);
        send_zero(333, 37, 1'b0);
        send_zero(341, 37, 1'b1);
        phase = 1;
        check(int'(divisor) == 37, "R3", "rounded average divisor", int'(divisor), 37);
        wait_ack();
        check(ack_frames == 1, "R6", "one ack frame at 37", ack_frames, 1);
        send_byte(8'hAA, 37, 1'b1, 3);
        check(fail && !done, "R8", "fail on 0xAA", int'({fail, done}), 2);
        repeat (100) @(negedge clk);
        check(fail && ack_frames == 1, "R10", "fail held", int'(fail), 1);
        check(clk_bad == 0, "R10", "per-clock model S2", clk_bad, 0);

        // S3: rate change between bytes, confirm with missing stop
        do_reset(1'b1, 30);
        hold(1'b1, 40);
        send_zero(180, 20, 1'b0);
        send_zero(270, 30, 1'b0);
        hold(1'b1, 20);
        check(ack_frames == 0 && divisor == 14'd0, "R4", "no lock on mismatch",
              int'(divisor), 0);
        send_zero(270, 30, 1'b1);
        phase = 1;
        check(int'(divisor) == 30, "R4", "lock on new reference", int'(divisor), 30);
        wait_ack();
        check(ack_frames == 1, "R6", "one ack frame at 30", ack_frames, 1);
        send_byte(8'h55, 30, 1'b0, 3);
        check(fail && !done, "R9", "fail on missing stop", int'({fail, done}), 2);
        check(clk_bad == 0, "R10", "per-clock model S3", clk_bad, 0);

        // S4: line low across reset release, single zero, glitch, then lock
        do_reset(1'b0, 30);
        hold(1'b0, 270);
        hold(1'b1, 60);
        send_zero(270, 30, 1'b0);
        hold(1'b1, 100);
        check(ack_frames == 0 && divisor == 14'd0, "R2", "no lock from held-low start",
              int'(divisor), 0);
        hold(1'b0, 5);
        hold(1'b1, 60);
        send_zero(270, 30, 1'b1);
        phase = 1;
        check(int'(divisor) == 30, "R5", "glitch ignored, lock", int'(divisor), 30);
        wait_ack();
        send_byte(8'h55, 30, 1'b1, 2);
        check(done && !fail, "R7", "done after held-low start", int'({done, fail}), 2);
        check(clk_bad == 0, "R10", "per-clock model S4", clk_bad, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule